// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Router with Acknowledge

This block collects a parameterised set of level-sensitive interrupt inputs and delivers each one to one or more of up to four processors. A source reaches a processor only when three conditions hold at once. The source must be switched on in a shared enable set. It must be unmasked in that processor's private mask. Its routing word must name that processor. Software never reads or modifies whole bit vectors. To flip one enable or mask bit, it writes the source number to a dedicated "turn on" or "turn off" address.

Each processor owns a local register window with an acknowledge word. Reading that word returns the number of the lowest-numbered source currently qualifying for that processor. When nothing qualifies, it returns a spurious code. Source numbers 0 and 1 carry summary lines from doorbell logic. Source number 5 is a private timer source: each processor has its own timer line, and only that processor's mask gates it. Every processor also has a registered interrupt output, raised while anything qualifies for it.

Top module: `mcpu_irq_hub`

## Requirements
- R1: After reset every `irq_out` bit is 0, every acknowledge read returns 1023, and every routing word reads 0 (all sources disabled and masked for every processor).
- R2: A read of global offset 0x000 returns the number of implemented sources in bits [11:2], with all other bits 0.
- R3: Writing a source number to global offset 0x030 enables that source and writing it to 0x034 disables it. A written value not below the number of sources (whole 32-bit word compared) changes nothing.
- R4: Writing a source number to local offset 0x048 masks that source for the processor selected by `bus_cpu`, and writing it to 0x04C unmasks it. No other processor's mask changes.
- R5: The routing word of source i sits at global offset 0x100 + 4*i. Bit c of it (bits [3:0]) selects processor c as a target. It reads back the written low bits, and a source reaches only processors whose bit is 1.
- R6: A read of local offset 0x044 returns in bits [9:0] the lowest-numbered source qualifying for that processor, with bits [31:10] zero. It returns 1023 when none qualifies.
- R7: Sources are level-sensitive: an acknowledge read does not clear anything, and a source stops qualifying as soon as its input drops.
- R8: Inputs `src_in[0]` and `src_in[1]` (doorbell summaries) are ordinary qualifying sources 0 and 1 and therefore win over every other source.
- R9: Source 5 qualifies for processor c when `timer_in[c]` is 1 and processor c has source 5 unmasked, regardless of global enable and routing. `src_in[5]` has no effect.
- R10: `irq_out[c]` is registered: it equals, one clock later, whether any source qualified for processor c.
- R11: Writes to any other address or to an unaligned routing address change nothing. Reads of unmapped addresses return 0. Read data appears the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | SRC_N | Level inputs of the shared sources |
| timer_in | input | CPU_N | Per-processor timer lines (source 5) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_local | input | 1 | 1 selects the local window of `bus_cpu`, 0 the global window |
| bus_cpu | input | CPU_W | Processor issuing the access |
| bus_addr | input | 12 | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | CPU_N | Registered per-processor interrupt request |

## Verification
The selection logic is driven with one source alone, then with several sources raised together and withdrawn one at a time from the lowest upward. This shows whether the lowest number truly wins, as opposed to the highest or the first enabled. Gating is tested by toggling one condition at a time: enable, each processor's mask, and routing bits. This tells a shared enable apart from a private mask. The timer source is raised on one processor's line while its shared input, enable and routing are set the opposite way, which separates the private-timer path from the ordinary one. Out-of-range index writes are chosen to alias an active source in their low bits, so a decoder that truncates is caught.

// File: rtl/hub_pkg.sv
package hub_pkg;
  localparam int HUB_AW = 12;
  localparam int HUB_DW = 32;
  localparam int ID_W   = 10;

  localparam logic [HUB_AW-1:0] OFS_CTRL    = 12'h000;
  localparam logic [HUB_AW-1:0] OFS_EN_SET  = 12'h030;
  localparam logic [HUB_AW-1:0] OFS_EN_CLR  = 12'h034;
  localparam logic [HUB_AW-1:0] OFS_ACK     = 12'h044;
  localparam logic [HUB_AW-1:0] OFS_MSK_SET = 12'h048;
  localparam logic [HUB_AW-1:0] OFS_MSK_CLR = 12'h04C;
  localparam logic [HUB_AW-1:0] OFS_ROUTE   = 12'h100;

  localparam logic [ID_W-1:0] ID_NONE = 10'h3FF;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_EN_SET,
    OP_EN_CLR,
    OP_MSK_SET,
    OP_MSK_CLR,
    OP_ROUTE
  } hub_op_e;
endpackage

// File: rtl/hub_decode.sv
module hub_decode
  import hub_pkg::*;
#(
  parameter int SRC_N = 32,
  parameter int IDX_W = 5
) (
  input  logic              wr,
  input  logic              loc,
  input  logic [HUB_AW-1:0] addr,
  input  logic [HUB_DW-1:0] wdata,
  output hub_op_e           op,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              route_hit,
  output logic [IDX_W-1:0]  route_idx
);
  localparam logic [HUB_AW-1:0] SRC_A = HUB_AW'(SRC_N);
  localparam logic [HUB_DW-1:0] SRC_D = HUB_DW'(SRC_N);

  logic [HUB_AW-1:0] rel;
  logic              idx_ok;

  assign rel       = addr - OFS_ROUTE;
  assign route_hit = !loc && (addr >= OFS_ROUTE) && (rel[1:0] == 2'b00)
                     && ((rel >> 2) < SRC_A);
  assign route_idx = rel[IDX_W+1:2];
  assign idx_ok    = wdata < SRC_D;
  assign wr_idx    = wdata[IDX_W-1:0];

  always_comb begin
    op = OP_NONE;
    if (wr) begin
      if (!loc) begin
        if (addr == OFS_EN_SET && idx_ok)      op = OP_EN_SET;
        else if (addr == OFS_EN_CLR && idx_ok) op = OP_EN_CLR;
        else if (route_hit)                    op = OP_ROUTE;
      end else begin
        if (addr == OFS_MSK_SET && idx_ok)      op = OP_MSK_SET;
        else if (addr == OFS_MSK_CLR && idx_ok) op = OP_MSK_CLR;
      end
    end
  end
endmodule

// File: rtl/hub_state.sv
module hub_state
  import hub_pkg::*;
#(
  parameter int SRC_N = 32,
  parameter int CPU_N = 4,
  parameter int IDX_W = 5,
  parameter int CPU_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  hub_op_e                     op,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [IDX_W-1:0]            route_idx,
  input  logic [CPU_N-1:0]            route_val,
  input  logic [CPU_W-1:0]            cpu,
  input  logic                        cpu_ok,
  output logic [SRC_N-1:0]            en,
  output logic [CPU_N-1:0][SRC_N-1:0] msk,
  output logic [SRC_N-1:0][CPU_N-1:0] route
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= '0;
      msk   <= '1;
      route <= '0;
    end else begin
      case (op)
        OP_EN_SET: en[wr_idx] <= 1'b1;
        OP_EN_CLR: en[wr_idx] <= 1'b0;
        OP_MSK_SET: if (cpu_ok) msk[cpu][wr_idx] <= 1'b1;
        OP_MSK_CLR: if (cpu_ok) msk[cpu][wr_idx] <= 1'b0;
        OP_ROUTE:  route[route_idx] <= route_val;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hub_pick.sv
module hub_pick
  import hub_pkg::*;
#(
  parameter int SRC_N    = 32,
  parameter int TIMER_ID = 5
) (
  input  logic [SRC_N-1:0] lvl,
  input  logic [SRC_N-1:0] en,
  input  logic [SRC_N-1:0] msk,
  input  logic [SRC_N-1:0] rte,
  input  logic             timer,
  output logic             found,
  output logic [ID_W-1:0]  id
);
  logic [SRC_N-1:0] q;

  for (genvar s = 0; s < SRC_N; s++) begin : g_q
    if (s == TIMER_ID) begin : g_tmr
      assign q[s] = timer & ~msk[s];
    end else begin : g_src
      assign q[s] = lvl[s] & en[s] & ~msk[s] & rte[s];
    end
  end

  always_comb begin
    found = 1'b0;
    id    = ID_NONE;
    for (int s = SRC_N - 1; s >= 0; s--) begin
      if (q[s]) begin
        found = 1'b1;
        id    = ID_W'(s);
      end
    end
  end
endmodule

// File: rtl/mcpu_irq_hub.sv
module mcpu_irq_hub
  import hub_pkg::*;
#(
  parameter int SRC_N    = 32,
  parameter int CPU_N    = 4,
  parameter int TIMER_ID = 5,
  parameter int CPU_W    = (CPU_N > 1) ? $clog2(CPU_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  src_in,
  input  logic [CPU_N-1:0]  timer_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_local,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [HUB_AW-1:0] bus_addr,
  input  logic [HUB_DW-1:0] bus_wdata,
  output logic [HUB_DW-1:0] bus_rdata,
  output logic [CPU_N-1:0]  irq_out
);
  localparam int IDX_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;
  localparam logic [ID_W-1:0] SRC_ID = ID_W'(SRC_N);

  hub_op_e                     op;
  logic [IDX_W-1:0]            wr_idx;
  logic                        route_hit;
  logic [IDX_W-1:0]            route_idx;
  logic                        cpu_ok;
  logic [SRC_N-1:0]            en;
  logic [CPU_N-1:0][SRC_N-1:0] msk;
  logic [SRC_N-1:0][CPU_N-1:0] route;
  logic [CPU_N-1:0][SRC_N-1:0] route_col;
  logic [CPU_N-1:0]            found;
  logic [CPU_N-1:0][ID_W-1:0]  ack_id;
  logic [HUB_DW-1:0]           rd_next;

  assign cpu_ok = int'(bus_cpu) < CPU_N;

  hub_decode #(.SRC_N(SRC_N), .IDX_W(IDX_W)) dec_i (
    .wr(bus_wr), .loc(bus_local), .addr(bus_addr), .wdata(bus_wdata),
    .op(op), .wr_idx(wr_idx), .route_hit(route_hit), .route_idx(route_idx)
  );

  hub_state #(.SRC_N(SRC_N), .CPU_N(CPU_N), .IDX_W(IDX_W), .CPU_W(CPU_W)) st_i (
    .clk(clk), .rst(rst), .op(op), .wr_idx(wr_idx), .route_idx(route_idx),
    .route_val(bus_wdata[CPU_N-1:0]), .cpu(bus_cpu), .cpu_ok(cpu_ok),
    .en(en), .msk(msk), .route(route)
  );

  for (genvar c = 0; c < CPU_N; c++) begin : g_cpu
    for (genvar s = 0; s < SRC_N; s++) begin : g_col
      assign route_col[c][s] = route[s][c];
    end
    hub_pick #(.SRC_N(SRC_N), .TIMER_ID(TIMER_ID)) pick_i (
      .lvl(src_in), .en(en), .msk(msk[c]), .rte(route_col[c]),
      .timer(timer_in[c]), .found(found[c]), .id(ack_id[c])
    );
  end

  always_comb begin
    rd_next = '0;
    if (!bus_local) begin
      if (bus_addr == OFS_CTRL)  rd_next[ID_W+1:2]  = SRC_ID;
      else if (route_hit)        rd_next[CPU_N-1:0] = route[route_idx];
    end else if (bus_addr == OFS_ACK && cpu_ok) begin
      rd_next[ID_W-1:0] = ack_id[bus_cpu];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= '0;
    end else begin
      irq_out <= found;
      if (bus_rd) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/hub_chk.sv
module hub_chk
  import hub_pkg::*;
#(
  parameter int SRC_N = 32,
  parameter int CPU_N = 4,
  parameter int CPU_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [SRC_N-1:0]  src_in,
  input logic [CPU_N-1:0]  timer_in,
  input logic              bus_rd,
  input logic              bus_local,
  input logic [CPU_W-1:0]  bus_cpu,
  input logic [HUB_AW-1:0] bus_addr,
  input logic [HUB_DW-1:0] bus_rdata,
  input logic [CPU_N-1:0]  irq_out
);
  logic ack_rd;
  logic ctrl_rd;
  assign ack_rd  = bus_rd && bus_local && bus_addr == OFS_ACK;
  assign ctrl_rd = bus_rd && !bus_local && bus_addr == OFS_CTRL;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> irq_out == '0);

  assert_ctrl_count_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl_rd)) |-> bus_rdata == (HUB_DW'(SRC_N) << 2));

  assert_ack_range_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ack_rd)) |->
      (bus_rdata[HUB_DW-1:ID_W] == '0 &&
       (int'(bus_rdata[ID_W-1:0]) < SRC_N || bus_rdata[ID_W-1:0] == ID_NONE)));

  assert_idle_inputs_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(src_in == '0 && timer_in == '0)) |-> irq_out == '0);

  for (genvar c = 0; c < CPU_N; c++) begin : g_c
    assert_ack_irq_agree_R10: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ack_rd && int'(bus_cpu) == c)) |->
        ((bus_rdata[ID_W-1:0] != ID_NONE) == irq_out[c]));
  end
endmodule

bind mcpu_irq_hub hub_chk #(.SRC_N(SRC_N), .CPU_N(CPU_N), .CPU_W(CPU_W)) chk_i (
  .clk(clk), .rst(rst), .src_in(src_in), .timer_in(timer_in), .bus_rd(bus_rd),
  .bus_local(bus_local), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_out(irq_out)
);

// File: tb/mcpu_irq_hub_tb_top.sv
module mcpu_irq_hub_tb_top;
  localparam int SRC_N = 32;
  localparam int CPU_N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_in = '0;
  logic [3:0]  timer_in = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_local = 1'b0;
  logic [1:0]  bus_cpu = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_out;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mcpu_irq_hub #(.SRC_N(SRC_N), .CPU_N(CPU_N), .TIMER_ID(5)) dut_i (
    .clk(clk), .rst(rst), .src_in(src_in), .timer_in(timer_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_local(bus_local), .bus_cpu(bus_cpu),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_in = '0; timer_in = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic loc, input int cpu, input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_local = loc; bus_cpu = 2'(cpu); bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic loc, input int cpu, input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_local = loc; bus_cpu = 2'(cpu); bus_addr = 12'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack(input int cpu, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(1'b1, cpu, 'h044, v);
    chk(tag, v, exp);
  endtask

  task automatic irq(input logic [3:0] exp, input string tag);
    @(negedge clk);
    chk(tag, {28'b0, irq_out}, {28'b0, exp});
  endtask

  // enable a source, route it, and unmask it on every routed processor
  task automatic arm(input int s, input logic [3:0] cpus);
    wr(1'b0, 0, 'h030, s);
    wr(1'b0, 0, 'h100 + 4 * s, {28'b0, cpus});
    for (int c = 0; c < 4; c++) if (cpus[c]) wr(1'b1, c, 'h04C, s);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 irq after reset", {28'b0, irq_out}, 32'h0);
    for (int c = 0; c < 4; c++) ack(c, 32'd1023, "R1 ack after reset");
    rd(1'b0, 0, 'h100 + 4 * 7, v);
    chk("R1 route after reset", v, 32'h0);
    src_in = 32'hFFFF_FFFF;
    wr(1'b0, 0, 'h030, 9);
    wr(1'b0, 0, 'h100 + 4 * 9, 32'h1);
    ack(0, 32'd1023, "R1 masked after reset");
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    do_reset();
    rd(1'b0, 0, 'h000, v);
    chk("R2 source count", v, 32'(SRC_N) << 2);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    do_reset();
    src_in[7] = 1'b1;
    wr(1'b0, 0, 'h100 + 4 * 7, 32'h4);
    wr(1'b1, 2, 'h04C, 7);
    ack(2, 32'd1023, "R3 not yet enabled");
    wr(1'b0, 0, 'h030, 7);
    ack(2, 32'd7, "R3 enabled");
    irq(4'b0100, "R10 irq follows enable");
    ack(0, 32'd1023, "R5 not routed to cpu0");
    rd(1'b0, 0, 'h100 + 4 * 7, v);
    chk("R5 route readback", v, 32'h4);
    wr(1'b0, 0, 'h034, 39);
    ack(2, 32'd7, "R3 out-of-range clear ignored");
    wr(1'b0, 0, 'h034, 32'h0001_0007);
    ack(2, 32'd7, "R3 upper-bit index ignored");
    wr(1'b0, 0, 'h034, 7);
    ack(2, 32'd1023, "R3 disabled");
    irq(4'b0000, "R10 irq follows disable");
  endtask

  task automatic t_mask();
    do_reset();
    src_in[7] = 1'b1;
    arm(7, 4'b0110);
    ack(1, 32'd7, "R5 cpu1 target");
    ack(2, 32'd7, "R5 cpu2 target");
    ack(3, 32'd1023, "R5 cpu3 not target");
    wr(1'b1, 1, 'h048, 7);
    ack(1, 32'd1023, "R4 masked on cpu1");
    ack(2, 32'd7, "R4 cpu2 unaffected");
    irq(4'b0100, "R4 irq per cpu");
  endtask

  task automatic t_priority();
    do_reset();
    arm(3, 4'b0001); arm(9, 4'b0001); arm(20, 4'b0001);
    src_in[20] = 1'b1; src_in[9] = 1'b1; src_in[3] = 1'b1;
    ack(0, 32'd3, "R6 lowest of three");
    src_in[3] = 1'b0;
    ack(0, 32'd9, "R6 next lowest");
    src_in[9] = 1'b0;
    ack(0, 32'd20, "R6 last remaining");
  endtask

  task automatic t_level();
    do_reset();
    arm(12, 4'b1000);
    src_in[12] = 1'b1;
    ack(3, 32'd12, "R7 first read");
    ack(3, 32'd12, "R7 read does not clear");
    src_in[12] = 1'b0;
    ack(3, 32'd1023, "R7 input dropped");
    irq(4'b0000, "R7 irq dropped");
  endtask

  task automatic t_doorbell();
    do_reset();
    arm(0, 4'b1000); arm(1, 4'b1000); arm(2, 4'b1000);
    src_in[2] = 1'b1; src_in[1] = 1'b1;
    ack(3, 32'd1, "R8 doorbell 1 wins");
    src_in[0] = 1'b1;
    ack(3, 32'd0, "R8 doorbell 0 wins");
  endtask

  task automatic t_timer();
    do_reset();
    src_in[5] = 1'b1;
    arm(5, 4'b0001);
    ack(0, 32'd1023, "R9 shared input ignored");
    timer_in[1] = 1'b1; timer_in[2] = 1'b1;
    wr(1'b1, 1, 'h04C, 5);
    ack(1, 32'd5, "R9 timer on cpu1");
    ack(2, 32'd1023, "R9 timer masked on cpu2");
    wr(1'b0, 0, 'h034, 5);
    ack(1, 32'd5, "R9 global enable ignored");
    irq(4'b0010, "R9 irq cpu1 only");
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    do_reset();
    wr(1'b0, 0, 'h100 + 4 * 4, 32'h2);
    wr(1'b0, 0, 'h101 + 4 * 4, 32'h8);
    rd(1'b0, 0, 'h100 + 4 * 4, v);
    chk("R11 unaligned route write ignored", v, 32'h2);
    wr(1'b0, 0, 'h000, 32'hFFFF_FFFF);
    rd(1'b0, 0, 'h000, v);
    chk("R11 control not writable", v, 32'(SRC_N) << 2);
    rd(1'b0, 0, 'h020, v);
    chk("R11 unmapped reads zero", v, 32'h0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_ctrl(); t_enable(); t_mask(); t_priority();
        t_level(); t_doorbell(); t_timer(); t_unmapped();
      end
      begin
        repeat (50000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule